// File: doc/BRIEF.md
# Indexed RGB Palette Port

This block holds a 256-entry colour lookup table and gives software access to it through four byte-wide registers. A write-index register picks the entry that the next data writes will fill. A read-index register picks the entry that the next data reads will return. One shared data register carries the colour components. A pixel mask register is applied to every incoming pixel before lookup. Each entry stores a red, green and blue component of six bits each. A small counter steps through the three components on every data access, and the index moves on to the next entry once blue has been transferred.

On the display side, a pixel port takes an 8-bit colour index each cycle. It ANDs that index with the mask and returns the stored RGB triple one cycle later. Display and register traffic share one storage port, and the display always wins. A data-register access that meets an active pixel request waits until a cycle with no pixel request. Index and mask accesses never touch the storage, so they are never held back.

Top module: `palette_port`

## Requirements
- R1: A write to the write-index register (address 0) loads the entry number and returns the write component counter to red, so the next data write lands in the red field of that entry.
- R2: Consecutive writes to the data register (address 1) store red, green and blue of the current write entry, in that order. After the blue write, the write index increases by one.
- R3: Both indices wrap modulo 256. After all 256 entries are written starting at entry 0, reading the write-index register returns 0.
- R4: Data reads use the read index (address 2) and their own component counter, which a write of the read-index register resets to red. They return red, green and blue in order, and the read index increases by one after blue and wraps modulo 256.
- R5: Only bits 5:0 of a data write are stored. Bits 7:6 of every data read are zero.
- R6: The pixel mask register (address 3) resets to 0xFF and reads back its written value. The pixel index is ANDed with it before lookup, so with 0xFF the index is used unchanged.
- R7: When pix_en is sampled high, pix_valid is high on the next cycle and pix_rgb holds the entry at (pix_idx AND mask), packed as red in bits 17:12, green in 11:6 and blue in 5:0. When pix_en is low, pix_valid is low on the next cycle.
- R8: A data-register access is not accepted in any cycle where pix_en is high. Index and mask accesses are accepted regardless of pix_en.
- R9: A held reg_req is accepted at the first clock edge allowed by R8. reg_ack is high for exactly the cycle after acceptance, and reg_rdata is valid in that cycle for a read.
- R10: After reset both indices and both component counters are zero, the mask is 0xFF, and reg_ack and pix_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request, held until reg_ack |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 write index, 1 data, 2 read index, 3 pixel mask |
| reg_wdata | input | 8 | Write data |
| reg_ack | output | 1 | Access completed (one cycle after acceptance) |
| reg_rdata | output | 8 | Read data, valid with reg_ack |
| pix_en | input | 1 | Pixel lookup request |
| pix_idx | input | 8 | Pixel colour index |
| pix_valid | output | 1 | pix_rgb valid |
| pix_rgb | output | 18 | Looked-up colour {red, green, blue} |

## Verification
The table is first filled with random bytes whose upper two bits are often set, so that truncation to six bits is visible. It is then read back as a full sweep while random pixel requests compete for the storage port. This separates correct component ordering and index stepping from errors in arbitration, because a stalled access that is wrongly taken would corrupt either the read stream or the pixel results. Directed cases cover a restart of the index in the middle of a triple on both sides, wrapping from entry 255, a narrow mask that folds high pixel indices onto low entries, and a data access held against a continuous pixel request while an index access goes through.

// File: rtl/palette_pkg.sv
package palette_pkg;
    localparam int CHAN_W = 6;
    localparam int BUS_W  = 8;

    typedef enum logic [1:0] {
        COMP_R = 2'd0,
        COMP_G = 2'd1,
        COMP_B = 2'd2
    } comp_e;

    typedef enum logic [1:0] {
        REG_WIDX = 2'd0,
        REG_DATA = 2'd1,
        REG_RIDX = 2'd2,
        REG_MASK = 2'd3
    } reg_e;

    typedef struct packed {
        logic [CHAN_W-1:0] r;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] b;
    } rgb_t;

    function automatic comp_e comp_next(comp_e c);
        case (c)
            COMP_R:  return COMP_G;
            COMP_G:  return COMP_B;
            default: return COMP_R;
        endcase
    endfunction
endpackage

// File: rtl/palette_store.sv
module palette_store
    import palette_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              pix_en,
    input  logic [IDX_W-1:0]  pix_addr,
    output rgb_t              pix_q,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [IDX_W-1:0]  acc_addr,
    input  comp_e             acc_comp,
    input  logic [CHAN_W-1:0] acc_wdata,
    output logic [CHAN_W-1:0] acc_q
);
    localparam int DEPTH = 1 << IDX_W;

    comp_e comp_q;

    for (genvar c = 0; c < 3; c++) begin : g_chan
        logic [CHAN_W-1:0] mem [DEPTH];
        logic [CHAN_W-1:0] pq;
        logic [CHAN_W-1:0] aq;

        always_ff @(posedge clk) begin
            if (pix_en) begin
                pq <= mem[pix_addr];
            end else if (acc_en) begin
                if (acc_we && acc_comp == comp_e'(c))
                    mem[acc_addr] <= acc_wdata;
                aq <= mem[acc_addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!pix_en && acc_en)
            comp_q <= acc_comp;
    end

    assign pix_q = '{r: g_chan[0].pq, g: g_chan[1].pq, b: g_chan[2].pq};

    always_comb begin
        case (comp_q)
            COMP_R:  acc_q = g_chan[0].aq;
            COMP_G:  acc_q = g_chan[1].aq;
            default: acc_q = g_chan[2].aq;
        endcase
    end

    // R8: the single storage port is never claimed by both sides at once
    always_ff @(posedge clk) begin
        assert_single_port_R8: assert (!(pix_en && acc_en))
            else $error("storage port claimed twice");
    end
endmodule

// File: rtl/palette_regs.sv
module palette_regs
    import palette_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic              reg_ack,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic              pix_en,
    output logic [IDX_W-1:0]  mask,
    output logic              acc_en,
    output logic              acc_we,
    output logic [IDX_W-1:0]  acc_addr,
    output comp_e             acc_comp,
    output logic [CHAN_W-1:0] acc_wdata,
    input  logic [CHAN_W-1:0] acc_q
);
    logic [IDX_W-1:0] widx, ridx;
    comp_e            wcomp, rcomp;
    logic             is_data, accept;
    logic             ack_q, from_store_q;
    logic [BUS_W-1:0] rdata_q;

    always_comb begin
        is_data   = (reg_e'(reg_addr) == REG_DATA);
        accept    = reg_req && !(is_data && pix_en);
        acc_en    = accept && is_data;
        acc_we    = reg_we;
        acc_addr  = reg_we ? widx : ridx;
        acc_comp  = reg_we ? wcomp : rcomp;
        acc_wdata = reg_wdata[CHAN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            widx         <= '0;
            ridx         <= '0;
            wcomp        <= COMP_R;
            rcomp        <= COMP_R;
            mask         <= '1;
            ack_q        <= 1'b0;
            from_store_q <= 1'b0;
            rdata_q      <= '0;
        end else begin
            ack_q        <= accept;
            from_store_q <= accept && is_data && !reg_we;
            if (accept && reg_we) begin
                case (reg_e'(reg_addr))
                    REG_WIDX: begin
                        widx  <= IDX_W'(reg_wdata);
                        wcomp <= COMP_R;
                    end
                    REG_DATA: begin
                        wcomp <= comp_next(wcomp);
                        if (wcomp == COMP_B) widx <= widx + 1'b1;
                    end
                    REG_RIDX: begin
                        ridx  <= IDX_W'(reg_wdata);
                        rcomp <= COMP_R;
                    end
                    default: mask <= IDX_W'(reg_wdata);
                endcase
            end else if (accept) begin
                case (reg_e'(reg_addr))
                    REG_WIDX: rdata_q <= BUS_W'(widx);
                    REG_DATA: begin
                        rcomp <= comp_next(rcomp);
                        if (rcomp == COMP_B) ridx <= ridx + 1'b1;
                    end
                    REG_RIDX: rdata_q <= BUS_W'(ridx);
                    default:  rdata_q <= BUS_W'(mask);
                endcase
            end
        end
    end

    assign reg_ack   = ack_q;
    assign reg_rdata = from_store_q ? BUS_W'(acc_q) : rdata_q;

    // R2: component counters never leave the three legal values
    assert_comp_legal_R2: assert property (@(posedge clk) disable iff (rst)
        (wcomp != comp_e'(2'd3)) && (rcomp != comp_e'(2'd3)));

    // R2: the write index steps once the blue component is stored
    assert_widx_step_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && reg_we && is_data && wcomp == COMP_B)
        |=> (widx == IDX_W'($past(widx) + 1'b1)));

    // R4: the read index steps once the blue component is returned
    assert_ridx_step_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && !reg_we && is_data && rcomp == COMP_B)
        |=> (ridx == IDX_W'($past(ridx) + 1'b1)));

    // R8: a data access colliding with a pixel request is not acknowledged
    assert_pix_priority_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_req && is_data && pix_en) |=> !reg_ack);

    // R9: an acknowledge always follows a request
    assert_ack_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
        reg_ack |-> $past(reg_req));

    // R6: the mask only changes through a mask write
    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(accept && reg_we && reg_e'(reg_addr) == REG_MASK) |=> $stable(mask));
endmodule

// File: rtl/palette_port.sv
module palette_port
    import palette_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_req,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [BUS_W-1:0]    reg_wdata,
    output logic                reg_ack,
    output logic [BUS_W-1:0]    reg_rdata,
    input  logic                pix_en,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic                pix_valid,
    output logic [3*CHAN_W-1:0] pix_rgb
);
    logic [IDX_W-1:0]  mask;
    logic              acc_en, acc_we;
    logic [IDX_W-1:0]  acc_addr;
    comp_e             acc_comp;
    logic [CHAN_W-1:0] acc_wdata, acc_q;
    rgb_t              pix_q;
    logic              valid_q;

    palette_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .pix_en(pix_en), .mask(mask),
        .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_comp(acc_comp), .acc_wdata(acc_wdata), .acc_q(acc_q)
    );

    palette_store #(.IDX_W(IDX_W)) u_store (
        .clk(clk),
        .pix_en(pix_en), .pix_addr(pix_idx & mask), .pix_q(pix_q),
        .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_comp(acc_comp), .acc_wdata(acc_wdata), .acc_q(acc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= pix_en;
    end

    assign pix_valid = valid_q;
    assign pix_rgb   = pix_q;

    // R7: a pixel request yields a valid result on the following cycle
    assert_pix_latency_R7: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> pix_valid);

    // R7: no valid result without a request in the previous cycle
    assert_pix_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> !pix_valid);
endmodule

// File: tb/palette_port_tb.sv
module palette_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        reg_ack;
    logic [7:0]  reg_rdata;
    logic        pix_en = 1'b0;
    logic [7:0]  pix_idx = 8'd0;
    logic        pix_valid;
    logic [17:0] pix_rgb;

    int checks = 0;
    int fails  = 0;
    logic [5:0] mr [256];
    logic [5:0] mg [256];
    logic [5:0] mb [256];
    logic [7:0] mask_m = 8'hFF;
    bit reads_done = 0;

    always #2 clk = ~clk;

    palette_port u_dut (
        .clk(clk), .rst(rst),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .pix_en(pix_en), .pix_idx(pix_idx),
        .pix_valid(pix_valid), .pix_rgb(pix_rgb)
    );

    function automatic logic [17:0] exp_rgb(logic [7:0] idx);
        logic [7:0] e = idx & mask_m;
        return {mr[e], mg[e], mb[e]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic reg_access(input logic we, input logic [1:0] addr,
                              input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_addr = addr; reg_wdata = wd;
        do @(negedge clk); while (!reg_ack);
        rd = reg_rdata;
        reg_req = 1'b0;
    endtask

    task automatic wr(input logic [1:0] addr, input logic [7:0] wd);
        logic [7:0] d;
        reg_access(1'b1, addr, wd, d);
    endtask

    task automatic rd(input logic [1:0] addr, output logic [7:0] v);
        reg_access(1'b0, addr, 8'h00, v);
    endtask

    task automatic pix_lookup(input logic [7:0] idx, input string req);
        @(negedge clk);
        pix_en = 1'b1; pix_idx = idx;
        @(negedge clk);
        pix_en = 1'b0;
        chk(req, {31'd0, pix_valid}, 32'd1);
        chk(req, {14'd0, pix_rgb}, {14'd0, exp_rgb(idx)});
    endtask

    task automatic pixel_traffic();
        logic       prev_en  = 1'b0;
        logic [7:0] prev_idx = 8'd0;
        while (!reads_done) begin
            @(negedge clk);
            if (prev_en)
                chk("R7 random pixel", {14'd0, pix_rgb}, {14'd0, exp_rgb(prev_idx)});
            chk("R7 valid", {31'd0, pix_valid}, {31'd0, prev_en});
            pix_en  = ($urandom % 2) == 0;
            pix_idx = 8'($urandom);
            prev_en = pix_en; prev_idx = pix_idx;
        end
        @(negedge clk);
        if (prev_en)
            chk("R7 random pixel", {14'd0, pix_rgb}, {14'd0, exp_rgb(prev_idx)});
        pix_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v, r8, g8, b8;
        void'($urandom(32'h5EED_2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk("R10 ack low", {31'd0, reg_ack}, 32'd0);
        chk("R10 pix_valid low", {31'd0, pix_valid}, 32'd0);
        rd(2'd0, v); chk("R10 write index", {24'd0, v}, 32'd0);
        rd(2'd2, v); chk("R10 read index", {24'd0, v}, 32'd0);
        rd(2'd3, v); chk("R10 R6 mask reset", {24'd0, v}, 32'hFF);

        // R2 R5: fill every entry with random bytes
        wr(2'd0, 8'd0);
        for (int i = 0; i < 256; i++) begin
            r8 = 8'($urandom); g8 = 8'($urandom); b8 = 8'($urandom);
            if (i == 7) begin r8 = 8'hFF; g8 = 8'hC0; b8 = 8'h3F; end
            wr(2'd1, r8); wr(2'd1, g8); wr(2'd1, b8);
            mr[i] = r8[5:0]; mg[i] = g8[5:0]; mb[i] = b8[5:0];
        end
        // R3: write index wrapped back to 0
        rd(2'd0, v); chk("R3 write index wrap", {24'd0, v}, 32'd0);

        // R4 R5 R8: full read sweep under random pixel traffic
        wr(2'd2, 8'd0);
        fork
            pixel_traffic();
            begin
                for (int i = 0; i < 256; i++) begin
                    rd(2'd1, v); chk("R4 R5 red", {24'd0, v}, {26'd0, mr[i]});
                    rd(2'd1, v); chk("R4 R5 green", {24'd0, v}, {26'd0, mg[i]});
                    rd(2'd1, v); chk("R4 R5 blue", {24'd0, v}, {26'd0, mb[i]});
                end
                reads_done = 1;
            end
        join
        rd(2'd2, v); chk("R4 read index wrap", {24'd0, v}, 32'd0);

        // R1: restart write index mid-triple
        wr(2'd0, 8'd10); wr(2'd1, 8'h2A); mr[10] = 6'h2A;
        wr(2'd0, 8'd20);
        wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'hF3);
        mr[20] = 6'h11; mg[20] = 6'h22; mb[20] = 6'h33;
        rd(2'd0, v); chk("R1 R2 index after triple", {24'd0, v}, 32'd21);

        // R4: restart read index mid-triple
        wr(2'd2, 8'd5); rd(2'd1, v);
        wr(2'd2, 8'd20);
        rd(2'd1, v); chk("R1 R4 red restart", {24'd0, v}, 32'h11);
        rd(2'd1, v); chk("R1 R4 green", {24'd0, v}, 32'h22);
        rd(2'd1, v); chk("R4 R5 blue truncated", {24'd0, v}, 32'h33);
        wr(2'd2, 8'd10);
        rd(2'd1, v); chk("R1 partial red stored", {24'd0, v}, 32'h2A);

        // R3: wrap from entry 255
        wr(2'd0, 8'd255);
        wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03);
        mr[255] = 6'h01; mg[255] = 6'h02; mb[255] = 6'h03;
        rd(2'd0, v); chk("R3 wrap from 255", {24'd0, v}, 32'd0);
        pix_lookup(8'd255, "R7 entry 255");

        // R6: mask
        pix_lookup(8'd7, "R6 R7 mask FF passthrough");
        wr(2'd3, 8'h0F); mask_m = 8'h0F;
        rd(2'd3, v); chk("R6 mask readback", {24'd0, v}, 32'h0F);
        pix_lookup(8'hF3, "R6 masked 0xF3");
        pix_lookup(8'hA7, "R6 masked 0xA7");
        wr(2'd3, 8'hFF); mask_m = 8'hFF;
        pix_lookup(8'hA7, "R6 mask restored");

        // R8 R9: data access held off by continuous pixel requests
        @(negedge clk);
        pix_en = 1'b1; pix_idx = 8'd3;
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = 2'd1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 data stalled", {31'd0, reg_ack}, 32'd0);
        end
        reg_addr = 2'd2; reg_we = 1'b1; reg_wdata = 8'd20;
        @(negedge clk);
        chk("R8 index write not stalled", {31'd0, reg_ack}, 32'd1);
        reg_req = 1'b0;
        @(negedge clk);
        chk("R9 ack single cycle", {31'd0, reg_ack}, 32'd0);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = 2'd1;
        @(negedge clk);
        chk("R8 stalled again", {31'd0, reg_ack}, 32'd0);
        pix_en = 1'b0;
        @(negedge clk);
        chk("R9 ack after release", {31'd0, reg_ack}, 32'd1);
        chk("R9 R4 data with ack", {24'd0, reg_rdata}, 32'h11);
        reg_req = 1'b0;

        finish_run();
    end
endmodule